// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block turns a 6-bit operand specifier into an effective address for one instruction operand. The upper three bits give the addressing mode, 0 to 7, and the lower three bits give the register index. The sequencer reads and updates an external 8-entry, 16-bit register file. Index 6 is the hardware stack pointer and index 7 is the program counter. When a mode needs an index word from the instruction stream or a pointer held in memory, the sequencer issues word reads on a valid/ready read port.

When it finishes, the sequencer raises `done` for one cycle. It then reports one of two results: a register operand (`is_reg` with `reg_num`), or a final memory address in `ea`.

The surrounding datapath pulses `start` with a specifier and an operand-size flag. It then waits for `done`. Instruction decode, the ALU and the movement of operand data all lie outside this block.

Top module: `operand_ea_seq`

## Requirements
- R1: Mode 0 (spec[5:3]=0) reports `is_reg`=1 with `reg_num`=spec[2:0]. It makes no memory request and no register write.
- R2: Mode 1 returns the register value as `ea`. It makes no memory request and no register write.
- R3: Mode 2 returns the old register value as `ea`. It then writes back the register plus the step.
- R4: Mode 4 writes back the register minus the step. It returns that decremented value as `ea`.
- R5: The step for registers 6 and 7 is always 2. For registers 0 to 5 the step is 1 when `byte_op`=1 and 2 when `byte_op`=0.
- R6: Modes 6 and 7 first read the word at the program counter and advance the program counter by 2. Mode 6 then returns that word plus the base register, modulo 2^16. When the base register is 7, the base is the program counter after it has advanced.
- R7: Modes 3, 5 and 7 compute the address of their non-deferred counterpart, read the word there, and return that word as `ea`. Modes 3 and 5 step the register by 2 whatever the operand size.
- R8: Mode 2 on register 7 returns the current program counter as `ea`, which points at the immediate word. It then advances the program counter by 2.
- R9: Each specifier causes exactly one register write in modes 2 to 7, and none in modes 0 and 1.
- R10: `done` is high for exactly one cycle per accepted specifier. `busy` is high from the cycle after acceptance through that `done` cycle. A `start` raised while `busy` is high is ignored.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one specifier; accepted only when idle |
| spec | input | 6 | [5:3] addressing mode, [2:0] register index |
| byte_op | input | 1 | 1 = byte-sized operand, 0 = word-sized operand |
| busy | output | 1 | Sequencer is working on a specifier |
| done | output | 1 | One-cycle completion strobe |
| is_reg | output | 1 | Result is a register operand (valid with done) |
| reg_num | output | 3 | Register index of the specifier |
| ea | output | 16 | Final memory address (valid with done when is_reg=0) |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read; mem_rdata valid in that cycle |
| mem_req_addr | output | 16 | Word read address |
| mem_rdata | input | 16 | Word read data |

## Verification
The hardest case is the index-deferred mode on a slow memory. Two fetches in sequence must each hold their address through several wait cycles. The program counter must advance exactly once, between the two fetches. A second `start` must arrive in the middle of all this and be ignored.

The bench reaches this case with a memory model whose ready latency is set per scenario. It injects a stray `start` two cycles into a long operation. It also runs indexed mode with register 7 as the base, and with a base near 0xFFFF, to cover the post-advance base and the 16-bit wrap.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH_INDEX,
      ST_FETCH_PTR,
      ST_DONE
   } seq_state_e;

   typedef enum logic [MODE_W-1:0] {
      AM_REG         = 3'd0,
      AM_REG_DEF     = 3'd1,
      AM_POSTINC     = 3'd2,
      AM_POSTINC_DEF = 3'd3,
      AM_PREDEC      = 3'd4,
      AM_PREDEC_DEF  = 3'd5,
      AM_INDEX       = 3'd6,
      AM_INDEX_DEF   = 3'd7
   } addr_mode_e;

endpackage

// File: rtl/opseq_step.sv
// Step generator: works out the inc/dec amount for one register and forms
// both the incremented and the decremented value.
module opseq_step #(
   parameter int          DATA_W       = 16,
   parameter int          NREG         = 8,
   parameter logic [NREG-1:0] WIDE_MASK = 8'b1100_0000,
   parameter bit          BYTE_STEP_EN = 1'b1,
   localparam int         REG_AW       = $clog2(NREG)
) (
   input  logic [REG_AW-1:0] reg_idx,
   input  logic              byte_op,
   input  logic              force_wide,
   input  logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] inc_val,
   output logic [DATA_W-1:0] dec_val
);
   logic [NREG-1:0]   wide_reg;
   logic [DATA_W-1:0] step;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_wide
      assign wide_reg[gi] = WIDE_MASK[gi];
   end

   if (BYTE_STEP_EN) begin : g_byte_step
      assign step = (byte_op && !force_wide && !wide_reg[reg_idx])
                  ? DATA_W'(1) : DATA_W'(2);
   end else begin : g_word_step
      logic unused_sel;
      assign unused_sel = ^{byte_op, force_wide, wide_reg, reg_idx};
      assign step = DATA_W'(2);
   end

   assign inc_val = value + step;
   assign dec_val = value - step;
endmodule

// File: rtl/opseq_memport.sv
// Read-port driver: a request is valid in either fetch state. The address is
// the program counter for an index word, or the latched pointer address.
module opseq_memport
   import opseq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  seq_state_e        state,
   input  logic [DATA_W-1:0] pc_val,
   input  logic [DATA_W-1:0] ptr_addr,
   output logic              req_valid,
   output logic [DATA_W-1:0] req_addr
);
   always_comb begin
      req_valid = 1'b0;
      req_addr  = ptr_addr;
      unique case (state)
         ST_FETCH_INDEX: begin
            req_valid = 1'b1;
            req_addr  = pc_val;
         end
         ST_FETCH_PTR: req_valid = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/operand_ea_seq.sv
module operand_ea_seq
   import opseq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int NREG         = 8,
   parameter int SP_IDX       = 6,
   parameter int PC_IDX       = 7,
   parameter bit BYTE_STEP_EN = 1'b1,
   localparam int REG_AW      = $clog2(NREG),
   localparam int SPEC_W      = MODE_W + REG_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SPEC_W-1:0] spec,
   input  logic              byte_op,
   output logic              busy,
   output logic              done,
   output logic              is_reg,
   output logic [REG_AW-1:0] reg_num,
   output logic [DATA_W-1:0] ea,
   output logic [REG_AW-1:0] rf_rd_idx,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [REG_AW-1:0] rf_wr_idx,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [DATA_W-1:0] mem_req_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam logic [REG_AW-1:0] PC_SEL   = REG_AW'(PC_IDX);
   localparam logic [NREG-1:0]   WIDE_SET = (NREG'(1) << SP_IDX) | (NREG'(1) << PC_IDX);
   localparam logic [DATA_W-1:0] PC_STEP  = DATA_W'(2);

   if (NREG != 8) begin : g_chk_nreg
      $error("operand_ea_seq: NREG must be 8 for a 3-bit register field");
   end
   if (DATA_W < 8) begin : g_chk_width
      $error("operand_ea_seq: DATA_W too small");
   end
   if (SP_IDX >= NREG || PC_IDX >= NREG || SP_IDX == PC_IDX) begin : g_chk_idx
      $error("operand_ea_seq: bad stack pointer / program counter index");
   end

   seq_state_e        state_q;
   addr_mode_e        mode_q;
   logic [REG_AW-1:0] reg_q;
   logic [DATA_W-1:0] base_q, ptr_q, ea_q;
   logic              is_reg_q;

   addr_mode_e        mode_in;
   logic [REG_AW-1:0] reg_in;
   logic              accept, handshake, force_wide;
   logic [DATA_W-1:0] inc_val, dec_val, pc_next, idx_base, idx_sum;

   assign mode_in   = addr_mode_e'(spec[SPEC_W-1:REG_AW]);
   assign reg_in    = spec[REG_AW-1:0];
   assign accept    = start && (state_q == ST_IDLE);
   assign handshake = mem_req_valid && mem_req_ready;
   assign force_wide = (mode_in == AM_POSTINC_DEF) || (mode_in == AM_PREDEC_DEF);

   always_comb begin
      unique case (state_q)
         ST_IDLE:        rf_rd_idx = reg_in;
         ST_FETCH_INDEX: rf_rd_idx = PC_SEL;
         default:        rf_rd_idx = reg_q;
      endcase
   end

   opseq_step #(
      .DATA_W(DATA_W), .NREG(NREG), .WIDE_MASK(WIDE_SET), .BYTE_STEP_EN(BYTE_STEP_EN)
   ) u_step (
      .reg_idx   (reg_in),
      .byte_op   (byte_op),
      .force_wide(force_wide),
      .value     (rf_rd_data),
      .inc_val   (inc_val),
      .dec_val   (dec_val)
   );

   opseq_memport #(.DATA_W(DATA_W)) u_memport (
      .state    (state_q),
      .pc_val   (rf_rd_data),
      .ptr_addr (ptr_q),
      .req_valid(mem_req_valid),
      .req_addr (mem_req_addr)
   );

   // In the fetch-index state the read port shows the program counter.
   assign pc_next  = rf_rd_data + PC_STEP;
   assign idx_base = (reg_q == PC_SEL) ? pc_next : base_q;
   assign idx_sum  = mem_rdata + idx_base;

   always_comb begin
      rf_wr_en   = 1'b0;
      rf_wr_idx  = reg_in;
      rf_wr_data = inc_val;
      if (accept) begin
         unique case (mode_in)
            AM_POSTINC, AM_POSTINC_DEF: rf_wr_en = 1'b1;
            AM_PREDEC, AM_PREDEC_DEF: begin
               rf_wr_en   = 1'b1;
               rf_wr_data = dec_val;
            end
            default: ;
         endcase
      end else if (state_q == ST_FETCH_INDEX && handshake) begin
         rf_wr_en   = 1'b1;
         rf_wr_idx  = PC_SEL;
         rf_wr_data = pc_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mode_q   <= AM_REG;
         reg_q    <= '0;
         base_q   <= '0;
         ptr_q    <= '0;
         ea_q     <= '0;
         is_reg_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               mode_q   <= mode_in;
               reg_q    <= reg_in;
               base_q   <= rf_rd_data;
               is_reg_q <= 1'b0;
               unique case (mode_in)
                  AM_REG: begin
                     is_reg_q <= 1'b1;
                     ea_q     <= '0;
                     state_q  <= ST_DONE;
                  end
                  AM_REG_DEF, AM_POSTINC: begin
                     ea_q    <= rf_rd_data;
                     state_q <= ST_DONE;
                  end
                  AM_PREDEC: begin
                     ea_q    <= dec_val;
                     state_q <= ST_DONE;
                  end
                  AM_POSTINC_DEF: begin
                     ptr_q   <= rf_rd_data;
                     state_q <= ST_FETCH_PTR;
                  end
                  AM_PREDEC_DEF: begin
                     ptr_q   <= dec_val;
                     state_q <= ST_FETCH_PTR;
                  end
                  default: state_q <= ST_FETCH_INDEX;
               endcase
            end
            ST_FETCH_INDEX: if (handshake) begin
               if (mode_q == AM_INDEX_DEF) begin
                  ptr_q   <= idx_sum;
                  state_q <= ST_FETCH_PTR;
               end else begin
                  ea_q    <= idx_sum;
                  state_q <= ST_DONE;
               end
            end
            ST_FETCH_PTR: if (handshake) begin
               ea_q    <= mem_rdata;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);
   assign is_reg  = is_reg_q;
   assign reg_num = reg_q;
   assign ea      = ea_q;
endmodule

// File: rtl/opseq_checker.sv
module opseq_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              is_reg,
   input logic              rf_wr_en,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [DATA_W-1:0] mem_req_addr
);
   logic wr_seen, mem_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen  <= 1'b0;
         mem_seen <= 1'b0;
      end else if (done) begin
         wr_seen  <= 1'b0;
         mem_seen <= 1'b0;
      end else begin
         if (rf_wr_en) wr_seen <= 1'b1;
         if (mem_req_valid && mem_req_ready) mem_seen <= 1'b1;
      end
   end

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> !wr_seen);

   assert_reg_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_reg) |-> (!mem_seen && !wr_seen));
endmodule

bind operand_ea_seq opseq_checker #(.DATA_W(DATA_W)) u_opseq_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .is_reg       (is_reg),
   .rf_wr_en     (rf_wr_en),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr)
);

// File: tb/operand_ea_seq_bench.sv
module operand_ea_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  spec = '0;
   logic        byte_op = 1'b0;
   logic        busy, done, is_reg;
   logic [2:0]  reg_num, rf_rd_idx, rf_wr_idx;
   logic [15:0] ea, rf_rd_data, rf_wr_data, mem_req_addr, mem_rdata;
   logic        rf_wr_en, mem_req_valid, mem_req_ready;

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_errs = 0;
   bit finished = 1'b0;

   logic [15:0] rf [8];
   logic        tb_ld = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [15:0] ld_val = '0;
   logic        tb_clr = 1'b0;
   int          lat = 0;
   int          wcnt;
   int          n_rd, n_wr, n_done, hold_err;
   logic        prev_stall;
   logic [15:0] prev_addr;

   function automatic logic [15:0] memval(logic [15:0] a);
      return 16'h0100 + {7'd0, a[8:1], 1'b0};
   endfunction

   assign rf_rd_data    = rf[rf_rd_idx];
   assign mem_rdata     = memval(mem_req_addr);
   assign mem_req_ready = mem_req_valid && (wcnt >= lat);

   always_ff @(posedge clk) begin
      if (tb_ld) rf[ld_idx] <= ld_val;
      else if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || tb_clr) begin
         wcnt <= 0; n_rd <= 0; n_wr <= 0; n_done <= 0; hold_err <= 0;
         prev_stall <= 1'b0; prev_addr <= '0;
      end else begin
         wcnt <= (mem_req_valid && !mem_req_ready) ? wcnt + 1 : 0;
         if (mem_req_valid && mem_req_ready) n_rd <= n_rd + 1;
         if (rf_wr_en) n_wr <= n_wr + 1;
         if (done) n_done <= n_done + 1;
         if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr))
            hold_err <= hold_err + 1;
         prev_stall <= mem_req_valid && !mem_req_ready;
         prev_addr  <= mem_req_addr;
      end
   end

   operand_ea_seq u_operand_ea_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
      .busy(busy), .done(done), .is_reg(is_reg), .reg_num(reg_num), .ea(ea),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rdata(mem_rdata)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_reg(int idx, logic [15:0] val);
      @(negedge clk);
      tb_ld = 1'b1; ld_idx = 3'(idx); ld_val = val;
      @(negedge clk);
      tb_ld = 1'b0;
   endtask

   // Runs one specifier and checks it against a model built from the requirements.
   task automatic run_op(string req, int md, int rn, bit bt, int latency, bit inject);
      logic [15:0] nv [8];
      logic [15:0] st, pc, p, w, base, exp_ea;
      int exp_rd, exp_wr, guard;
      for (int i = 0; i < 8; i++) nv[i] = rf[i];
      st = (rn >= 6 || md == 3 || md == 5 || !bt) ? 16'd2 : 16'd1;
      pc = rf[7];
      exp_rd = 0; exp_wr = 0; exp_ea = '0;
      case (md)
         1: exp_ea = rf[rn];
         2: begin exp_ea = rf[rn]; nv[rn] = rf[rn] + st; exp_wr = 1; end
         3: begin p = rf[rn]; nv[rn] = p + 16'd2; exp_ea = memval(p); exp_rd = 1; exp_wr = 1; end
         4: begin nv[rn] = rf[rn] - st; exp_ea = nv[rn]; exp_wr = 1; end
         5: begin p = rf[rn] - 16'd2; nv[rn] = p; exp_ea = memval(p); exp_rd = 1; exp_wr = 1; end
         6, 7: begin
            w = memval(pc); nv[7] = pc + 16'd2;
            base = (rn == 7) ? pc + 16'd2 : rf[rn];
            exp_ea = w + base; exp_rd = 1; exp_wr = 1;
            if (md == 7) begin exp_ea = memval(exp_ea); exp_rd = 2; end
         end
         default: ;
      endcase
      lat = latency;
      @(negedge clk);
      tb_clr = 1'b1;
      @(negedge clk);
      tb_clr = 1'b0;
      spec = 6'((md << 3) | rn); byte_op = bt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard = 0;
      while (!done && guard < 100) begin
         if (inject && guard == 1) begin start = 1'b1; spec = 6'o05; end
         if (inject && guard == 2) start = 1'b0;
         @(negedge clk);
         guard++;
      end
      start = 1'b0;
      chk({req, " done reached"}, 32'(done), 32'd1);
      chk({req, " is_reg"}, 32'(is_reg), 32'(md == 0));
      chk({req, " reg_num"}, 32'(reg_num), 32'(rn));
      if (md != 0) chk({req, " ea"}, 32'(ea), 32'(exp_ea));
      chk({req, " memory reads"}, 32'(n_rd), 32'(exp_rd));
      chk({req, " R9 register writes"}, 32'(n_wr), 32'(exp_wr));
      @(negedge clk);
      chk({req, " R10 done one cycle"}, 32'(done), 32'd0);
      repeat (3) @(negedge clk);
      chk({req, " R10 single done, idle after"}, 32'({n_done[7:0], busy}), 32'({8'd1, 1'b0}));
      chk({req, " R11 request held while stalled"}, 32'(hold_err), 32'd0);
      for (int i = 0; i < 8; i++) chk({req, " register file"}, 32'(rf[i]), 32'(nv[i]));
   endtask

   task automatic t_reset;
      chk("R10 reset busy/done", 32'({busy, done}), 32'd0);
      chk("R11 reset no request", 32'(mem_req_valid), 32'd0);
      chk("R9 reset no write", 32'(rf_wr_en), 32'd0);
   endtask

   task automatic t_register_direct;   run_op("R1 mode0 r3", 0, 3, 1'b0, 0, 1'b0); endtask
   task automatic t_register_deferred; run_op("R2 mode1 r2", 1, 2, 1'b1, 0, 1'b0); endtask
   task automatic t_postinc;
      run_op("R3 R5 postinc byte r1", 2, 1, 1'b1, 0, 1'b0);
      run_op("R3 R5 postinc word r1", 2, 1, 1'b0, 0, 1'b0);
   endtask
   task automatic t_predec;
      run_op("R4 R5 predec byte sp", 4, 6, 1'b1, 0, 1'b0);
      run_op("R4 R5 predec byte r4", 4, 4, 1'b1, 0, 1'b0);
   endtask
   task automatic t_immediate;         run_op("R8 R5 immediate byte", 2, 7, 1'b1, 0, 1'b0); endtask
   task automatic t_deferred_steps;
      run_op("R7 postinc deferred byte r0", 3, 0, 1'b1, 2, 1'b0);
      run_op("R7 predec deferred byte r5", 5, 5, 1'b1, 1, 1'b0);
   endtask
   task automatic t_indexed;
      run_op("R6 indexed r2", 6, 2, 1'b0, 3, 1'b0);
      run_op("R6 pc-relative", 6, 7, 1'b1, 0, 1'b0);
   endtask
   task automatic t_index_deferred_busy;
      run_op("R7 R10 index deferred r3 stray start", 7, 3, 1'b0, 3, 1'b1);
   endtask
   task automatic t_index_wrap;
      load_reg(4, 16'hFFF0);
      run_op("R6 indexed wrap r4", 6, 4, 1'b0, 2, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
         $finish;
      end
   end

   initial begin
      load_reg(0, 16'h0100); load_reg(1, 16'h0021); load_reg(2, 16'h0030);
      load_reg(3, 16'h0040); load_reg(4, 16'h0051); load_reg(5, 16'h0060);
      load_reg(6, 16'h0180); load_reg(7, 16'h0010);
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_register_direct();
      t_register_deferred();
      t_postinc();
      t_predec();
      t_immediate();
      t_deferred_steps();
      t_indexed();
      t_index_deferred_busy();
      t_index_wrap();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule